// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block sits beside a memory array and gives it load-linked / store-conditional semantics for a set of execution contexts. Each context is identified by a CPU number and a thread number, and owns one reservation slot holding a valid bit and a 16-byte granule address. The block sees every request going to the memory. It records a reservation when a context issues a locked read. It drops reservations when any store lands on their granule. For every store it decides whether the memory write may happen.

Ordinary stores always write, and they also cancel any reservation on the granule they touch. A store-conditional writes only when the requester's own reservation covers the target granule. Otherwise, including when the table is empty, it is suppressed. The pass/fail outcome is returned on a registered result bit. The memory data path is not part of this block.

Top module: `llsc_monitor`

## Requirements
- R1: After reset every reservation is empty, `sc_result_o` is 0, and `mem_we_o` is 0 while no request is presented.
- R2: Addresses are compared with bits [3:0] ignored. Two addresses in the same aligned 16-byte granule match. Adjacent granules do not match.
- R3: A locked read (`req_write_i`=0, `req_locked_i`=1) records its granule in the requesting context's slot. A second locked read from that context replaces the stored granule, so the old granule no longer matches.
- R4: A read with `req_locked_i`=0 leaves every reservation unchanged.
- R5: An ordinary store (`req_write_i`=1, `req_locked_i`=0) raises `mem_we_o` in the same cycle. On the next cycle `sc_result_o` is 0.
- R6: Any store whose granule matches reservations clears all of them, whichever contexts hold them.
- R7: A store-conditional (`req_write_i`=1, `req_locked_i`=1) whose own context holds a matching reservation raises `mem_we_o` in the same cycle. `sc_result_o` is 1 on the next cycle, and that reservation is consumed.
- R8: A store-conditional with no matching reservation of its own leaves `mem_we_o` at 0, and `sc_result_o` is 0 on the next cycle. This covers an empty table, a different granule, and a match held only by another context. It still clears other contexts' matching reservations.
- R9: `sc_result_o` changes only in the cycle after a valid request. It holds its value while `req_valid_i` is 0. Every valid request that is not a store-conditional loads 0.
- R10: The context index is {`req_cpu_i`, `req_thread_i`}. Two threads of one CPU are distinct contexts, and so are equal thread numbers on different CPUs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = store, 0 = read |
| req_locked_i | input | 1 | Locked flag: load-linked on reads, store-conditional on stores |
| req_addr_i | input | ADDR_W | Physical address |
| req_cpu_i | input | CPU_W | CPU number of the requester |
| req_thread_i | input | THR_W | Thread number of the requester |
| mem_we_o | output | 1 | Write enable gate to the memory, combinational |
| sc_result_o | output | 1 | Store-conditional outcome, registered, held between requests |

## Verification
The table is probed only through store-conditional outcomes. Each pattern is built so that success or failure tells one rule apart from another. Patterns in the same granule and in the adjacent granule separate the masking width. A repeated load-linked from one context separates overwrite from allocate. Reservations on one granule held by several contexts, followed by a plain store or a foreign store-conditional, show that the erase covers every match and not just the requester's. Plain reads placed between a reservation and its store-conditional, and idle gaps after a result, show that reads leave the table alone and that the result bit holds.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_READ,
    KIND_LL,
    KIND_STORE,
    KIND_SC
  } req_kind_e;
endpackage

// File: rtl/llsc_req_decode.sv
module llsc_req_decode
  import llsc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 4,
  parameter int CPU_W    = 1,
  parameter int THR_W    = 1,
  localparam int GW      = ADDR_W - GRAN_LSB,
  localparam int CTX_W   = CPU_W + THR_W
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic              locked_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CPU_W-1:0]  cpu_i,
  input  logic [THR_W-1:0]  thread_i,
  output req_kind_e         kind_o,
  output logic [GW-1:0]     gran_o,
  output logic [CTX_W-1:0]  ctx_o
);
  always_comb begin
    kind_o = KIND_NONE;
    if (valid_i) begin
      unique case ({write_i, locked_i})
        2'b00:   kind_o = KIND_READ;
        2'b01:   kind_o = KIND_LL;
        2'b10:   kind_o = KIND_STORE;
        default: kind_o = KIND_SC;
      endcase
    end
  end

  assign gran_o = GW'(addr_i >> GRAN_LSB);
  assign ctx_o  = {cpu_i, thread_i};
endmodule

// File: rtl/llsc_slot.sv
module llsc_slot #(
  parameter int GW = 28
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  input  logic          store_i,
  input  logic [GW-1:0] gran_i,
  output logic          valid_o,
  output logic          match_o
);
  logic          valid_q;
  logic [GW-1:0] gran_q;

  assign match_o = valid_q && (gran_q == gran_i);
  assign valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      gran_q  <= '0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      gran_q  <= gran_i;
    end else if (store_i && match_o) begin
      valid_q <= 1'b0;
    end
  end

  assert_erase_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && !alloc_i && match_o) |=> !valid_q);

  assert_alloc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |=> (valid_q && gran_q == $past(gran_i)));

  assert_idle_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alloc_i && !store_i) |=> ($stable(valid_q) && $stable(gran_q)));
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 4,
  parameter int CPU_W    = 1,
  parameter int THR_W    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_locked_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CPU_W-1:0]  req_cpu_i,
  input  logic [THR_W-1:0]  req_thread_i,
  output logic              mem_we_o,
  output logic              sc_result_o
);
  localparam int GW    = ADDR_W - GRAN_LSB;
  localparam int CTX_W = CPU_W + THR_W;
  localparam int NCTX  = 1 << CTX_W;

  req_kind_e        kind;
  logic [GW-1:0]    gran;
  logic [CTX_W-1:0] ctx;
  logic [NCTX-1:0]  slot_match;
  logic [NCTX-1:0]  slot_valid;
  logic             is_store;
  logic             own_hit;
  logic             sc_q;

  llsc_req_decode #(
    .ADDR_W  (ADDR_W),
    .GRAN_LSB(GRAN_LSB),
    .CPU_W   (CPU_W),
    .THR_W   (THR_W)
  ) u_dec (
    .valid_i (req_valid_i),
    .write_i (req_write_i),
    .locked_i(req_locked_i),
    .addr_i  (req_addr_i),
    .cpu_i   (req_cpu_i),
    .thread_i(req_thread_i),
    .kind_o  (kind),
    .gran_o  (gran),
    .ctx_o   (ctx)
  );

  assign is_store = (kind == KIND_STORE) || (kind == KIND_SC);

  for (genvar i = 0; i < NCTX; i++) begin : g_slot
    logic alloc;
    assign alloc = (kind == KIND_LL) && (ctx == CTX_W'(i));
    llsc_slot #(.GW(GW)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .alloc_i(alloc),
      .store_i(is_store),
      .gran_i (gran),
      .valid_o(slot_valid[i]),
      .match_o(slot_match[i])
    );
  end

  // A hit by another context never grants the conditional store
  assign own_hit  = slot_match[ctx];
  assign mem_we_o = (kind == KIND_STORE) || ((kind == KIND_SC) && own_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sc_q <= 1'b0;
    else if (req_valid_i) sc_q <= (kind == KIND_SC) && own_hit;
  end

  assign sc_result_o = sc_q;

  assert_sc_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_locked_i && mem_we_o) |=> sc_result_o);

  assert_sc_fail_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_locked_i && !mem_we_o) |=> !sc_result_o);

  assert_plain_store_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && !req_locked_i) |-> mem_we_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(sc_result_o));

  assert_non_sc_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !(req_write_i && req_locked_i)) |=> !sc_result_o);

  assert_no_req_no_we_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !mem_we_o);

  assert_store_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_store && slot_match[ctx]) |=> !slot_valid[$past(ctx)]);
endmodule

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        write = 1'b0;
  logic        locked = 1'b0;
  logic [31:0] addr = '0;
  logic        cpu = 1'b0;
  logic        thr = 1'b0;
  logic        we;
  logic        res;

  int  total = 0;
  int  fails = 0;
  bit  done = 0;
  bit  last_res = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  llsc_monitor dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (valid),
    .req_write_i (write),
    .req_locked_i(locked),
    .req_addr_i  (addr),
    .req_cpu_i   (cpu),
    .req_thread_i(thr),
    .mem_we_o    (we),
    .sc_result_o (res)
  );

  task automatic check(bit act, bit exp, string tag, string what);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Driver: presents one request, checks the same-cycle gate, queues the result
  task automatic req(bit w, bit l, logic [31:0] a, bit c, bit t,
                     bit exp_we, bit exp_res, string tag);
    @(negedge clk);
    valid = 1'b1; write = w; locked = l; addr = a; cpu = c; thr = t;
    #2;
    check(we, exp_we, tag, "mem_we_o");
    exp_q.push_back(exp_res);
    tag_q.push_back(tag);
    last_res = exp_res;
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    valid = 1'b0; write = 1'b0; locked = 1'b0;
    #2;
    check(we, 1'b0, tag, "mem_we_o idle");
    exp_q.push_back(last_res);
    tag_q.push_back(tag);
  endtask

  // Monitor: one posedge after a request, compare the registered result
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(res, e, t, "sc_result_o");
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #2;
    check(res, 1'b0, "R1", "sc_result_o in reset");
    check(we, 1'b0, "R1", "mem_we_o in reset");
    @(negedge clk);
    rst_n = 1'b1;

    // Empty table
    req(1, 1, 32'h100, 0, 0, 0, 0, "R8 empty table");
    req(1, 0, 32'h100, 0, 0, 1, 0, "R5 plain store");
    // Granule masking
    req(0, 1, 32'h100, 0, 0, 0, 0, "R3 ll");
    req(1, 1, 32'h10C, 0, 0, 1, 1, "R2 R7 same granule");
    req(1, 1, 32'h100, 0, 0, 0, 0, "R7 consumed");
    req(0, 1, 32'h90F, 0, 0, 0, 0, "R2 ll edge");
    req(1, 1, 32'h910, 0, 0, 0, 0, "R2 adjacent granule");
    req(1, 1, 32'h900, 0, 0, 1, 1, "R2 low granule ok");
    // Overwrite
    req(0, 1, 32'h200, 0, 0, 0, 0, "R3 ll first");
    req(0, 1, 32'h300, 0, 0, 0, 0, "R3 ll overwrite");
    req(1, 1, 32'h200, 0, 0, 0, 0, "R3 old granule gone");
    req(1, 1, 32'h300, 0, 0, 1, 1, "R3 new granule");
    // Multi-context erase by plain store
    req(0, 1, 32'h400, 0, 1, 0, 0, "R6 ll ctx1");
    req(0, 1, 32'h400, 1, 0, 0, 0, "R6 ll ctx2");
    req(1, 0, 32'h408, 1, 1, 1, 0, "R6 plain store");
    req(1, 1, 32'h400, 0, 1, 0, 0, "R6 ctx1 erased");
    req(1, 1, 32'h400, 1, 0, 0, 0, "R6 ctx2 erased");
    // Foreign SC fails and still erases
    req(0, 1, 32'h500, 0, 0, 0, 0, "R8 ll ctx0");
    req(1, 1, 32'h500, 0, 1, 0, 0, "R8 R10 other thread");
    req(1, 1, 32'h500, 0, 0, 0, 0, "R8 erased by failed sc");
    req(0, 1, 32'h580, 1, 1, 0, 0, "R10 ll cpu1 thr1");
    req(1, 1, 32'h580, 0, 1, 0, 0, "R10 cpu0 thr1");
    req(1, 1, 32'h580, 1, 1, 0, 0, "R10 erased");
    // Plain read and other-granule store leave table intact
    req(0, 1, 32'h600, 1, 1, 0, 0, "R4 ll ctx3");
    req(0, 0, 32'h700, 1, 1, 0, 0, "R4 plain read");
    req(0, 0, 32'h600, 0, 0, 0, 0, "R4 plain read same granule");
    req(1, 0, 32'h610, 0, 0, 1, 0, "R6 store other granule");
    req(1, 1, 32'h600, 1, 1, 1, 1, "R4 R7 kept");
    // Result hold
    idle("R9 hold 1");
    idle("R9 hold 2");
    idle("R9 hold 3");
    req(0, 0, 32'h000, 0, 0, 0, 0, "R9 read clears result");
    idle("R9 hold 0");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule